// File: doc/BRIEF.md
# DMA Channel Bus Controller

This block is one DMA channel that copies bytes from a peripheral into RAM by borrowing the system bus from the processor. A peripheral asks for service on a request line. The channel synchronises that line and asks the processor for the bus. Once the processor grants the bus, the channel runs the RAM write cycle itself. The channel then gives the bus back in a fixed order. The address bus is tri-statable at board level. The block models this with an address value plus an output-enable, so the channel drives the address only while the enable is high.

There are two transfer styles. In fly-by mode the peripheral puts its byte straight onto the data bus while the channel strobes the RAM write. In buffered mode the channel first reads the peripheral into a holding register and then writes that register to RAM in a second phase. Buffered mode spends one extra bus cycle per byte. The request line can be treated as edge-sensitive, giving one byte per rising edge, or as level-sensitive, where the channel keeps the bus and streams bytes while the request stays high.

Before a run, a small configuration port loads the start address, the byte count and both mode bits.

Top module: `dma_channel`

## Requirements
- R1: While reset is held and after it, the channel is idle: bus_req, dev_ack, addr_oe and data_oe are 0, wr_n and rd_n are 1, and done is 0.
- R2: dev_req passes through two synchronising flops. The resulting request sets bus_req on the third rising clock edge after dev_req goes high. Until bus_ack is seen, addr_oe, dev_ack and both strobes stay inactive.
- R3: In fly-by mode the cycle after the grant edge is a single write cycle. In it, addr_oe=1, dev_ack=1, wr_n=0 and data_oe=0, and addr_o holds the current byte address.
- R4: In the cycle after each write, dev_ack and addr_oe are already 0 while bus_req is still 1. When no further byte follows, bus_req falls in the cycle after that.
- R5: In edge mode exactly one byte is moved per rising edge of dev_req. Holding dev_req high moves only one byte, and every byte has its own bus tenure.
- R6: In level mode the channel keeps bus_req high between bytes for as long as the synchronised request stays high. Each byte then costs 2 bus cycles in fly-by mode and 3 in buffered mode. When the request falls, the bus is released after the byte in progress and the byte that the synchroniser lag lets through.
- R7: In buffered mode a read cycle comes first: rd_n=0, dev_ack=1, addr_oe=0. The write cycle follows, with wr_n=0, addr_oe=1, data_oe=1, dev_ack=0, and data_o equal to the byte sampled from data_i at the end of the read.
- R8: Each byte goes to the next address, wrapping modulo 2^ADDR_W. done rises in the cycle after the last write. While done is set, no new bus request is made.
- R9: A configuration load is taken only while the channel is idle and is ignored during a run. A load clears done, except that a load with length 0 sets done at once and no transfer starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Load configuration (taken only when idle) |
| cfg_base | input | ADDR_W | First RAM address of the run |
| cfg_len | input | CNT_W | Number of bytes to move |
| cfg_edge | input | 1 | 1 = edge-sensitive request, 0 = level-sensitive |
| cfg_buffered | input | 1 | 1 = buffered two-phase transfer, 0 = fly-by |
| dev_req | input | 1 | Asynchronous service request from the peripheral |
| dev_ack | output | 1 | Acknowledge to the peripheral |
| bus_req | output | 1 | Bus request to the processor |
| bus_ack | input | 1 | Bus grant from the processor |
| addr_o | output | ADDR_W | RAM address, meaningful while addr_oe is 1 |
| addr_oe | output | 1 | Address bus drive enable |
| wr_n | output | 1 | RAM write strobe, active low |
| rd_n | output | 1 | Peripheral read strobe, active low (buffered mode) |
| data_i | input | DATA_W | Peripheral data read in buffered mode |
| data_o | output | DATA_W | Held byte driven in the buffered write cycle |
| data_oe | output | 1 | Data bus drive enable |
| done | output | 1 | Run finished (count reached zero) |

## Verification
bus_req is due in the third sampled cycle after dev_req rises. The first read or write phase is due one cycle after the grant, the release cycle one cycle after the write, and bus_req falls one cycle after that. The bench counts these offsets tick by tick from the cycle in which it drives the request and samples each output at the falling edge of that exact cycle. Totals that depend on the synchroniser lag are checked as arithmetic counts: bytes written, tenures, and bus-busy cycles equal to one plus two or three per byte in level mode and three or four per byte in edge mode. These counts are checked once the bus is idle.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARB,
    ST_RD,
    ST_WR,
    ST_TAIL,
    ST_REL
  } dma_state_e;

  typedef struct packed {
    logic bus_req;
    logic dev_ack;
    logic addr_oe;
    logic data_oe;
    logic wr_n;
    logic rd_n;
  } dma_drv_t;

  localparam dma_drv_t DRV_OFF = '{bus_req: 1'b0, dev_ack: 1'b0, addr_oe: 1'b0,
                                   data_oe: 1'b0, wr_n: 1'b1, rd_n: 1'b1};

endpackage

// File: rtl/dma_req_sync.sv
module dma_req_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic req_async,
  output logic req_level,
  output logic req_rise
);
  localparam int TOP = STAGES - 1;

  logic [TOP:0] shreg;
  logic         last_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) shreg <= '0;
        else     shreg <= req_async;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) shreg <= '0;
        else     shreg <= {shreg[TOP-1:0], req_async};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= shreg[TOP];
  end

  assign req_level = shreg[TOP];
  assign req_rise  = shreg[TOP] & ~last_q;

  // R5: an edge event lasts one cycle only
  assert_rise_single_R5: assert property (@(posedge clk) disable iff (rst)
    req_rise |=> !req_rise);

endmodule

// File: rtl/dma_addr_cnt.sv
module dma_addr_cnt #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [CNT_W-1:0]  load_cnt,
  input  logic              step,
  output logic [ADDR_W-1:0] addr,
  output logic              cnt_zero,
  output logic              cnt_last
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      cnt_q  <= '0;
    end else if (load) begin
      addr_q <= load_addr;
      cnt_q  <= load_cnt;
    end else if (step) begin
      addr_q <= addr_q + 1'b1;
      cnt_q  <= cnt_q - ONE;
    end
  end

  assign addr     = addr_q;
  assign cnt_zero = (cnt_q == '0);
  assign cnt_last = (cnt_q == ONE);

  // R8: each byte moves the address on by one, modulo the address width
  assert_addr_step_R8: assert property (@(posedge clk) disable iff (rst)
    step |=> addr_q == ADDR_W'($past(addr_q) + 1'b1));

  // R8: a byte is never stepped with nothing left to move
  assert_no_underflow_R8: assert property (@(posedge clk) disable iff (rst)
    step |-> cnt_q != '0);

endmodule

// File: rtl/dma_ctrl.sv
module dma_ctrl
  import dma_chan_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_load,
  input  logic              cfg_edge,
  input  logic              cfg_buffered,
  input  logic              cfg_len_zero,
  input  logic              req_level,
  input  logic              req_rise,
  input  logic              bus_ack,
  input  logic              cnt_zero,
  input  logic              cnt_last,
  input  logic [DATA_W-1:0] data_i,
  output logic              load_ok,
  output logic              step,
  output logic              done,
  output logic [DATA_W-1:0] data_o,
  output dma_drv_t          drv
);

  dma_state_e        st_q, st_d;
  dma_drv_t          drv_q;
  logic              edge_q, buf_q, pend_q, done_q;
  logic              want, commit;
  logic [DATA_W-1:0] hold_q;

  function automatic dma_drv_t drive_of(dma_state_e s, logic buffered);
    dma_drv_t d;
    d = DRV_OFF;
    case (s)
      ST_ARB, ST_TAIL: d.bus_req = 1'b1;
      ST_RD: begin
        d.bus_req = 1'b1;
        d.dev_ack = 1'b1;
        d.rd_n    = 1'b0;
      end
      ST_WR: begin
        d.bus_req = 1'b1;
        d.addr_oe = 1'b1;
        d.wr_n    = 1'b0;
        d.dev_ack = ~buffered;
        d.data_oe = buffered;
      end
      default: d = DRV_OFF;
    endcase
    return d;
  endfunction

  assign load_ok = cfg_load && (st_q == ST_IDLE);
  assign commit  = (st_q == ST_ARB) && bus_ack;
  assign want    = edge_q ? (pend_q | req_rise) : req_level;
  assign step    = (st_q == ST_WR);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (!cfg_load && want && !cnt_zero && !done_q) st_d = ST_ARB;
      ST_ARB:  if (bus_ack) st_d = buf_q ? ST_RD : ST_WR;
      ST_RD:   st_d = ST_WR;
      ST_WR:   st_d = ST_TAIL;
      ST_TAIL: begin
        if (!edge_q && req_level && !done_q) st_d = buf_q ? ST_RD : ST_WR;
        else                                 st_d = ST_REL;
      end
      ST_REL:  if (!bus_ack) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      drv_q  <= DRV_OFF;
      edge_q <= 1'b0;
      buf_q  <= 1'b0;
      pend_q <= 1'b0;
      done_q <= 1'b0;
      hold_q <= '0;
    end else begin
      st_q  <= st_d;
      drv_q <= drive_of(st_d, buf_q);
      if (load_ok) begin
        edge_q <= cfg_edge;
        buf_q  <= cfg_buffered;
        pend_q <= 1'b0;
        done_q <= cfg_len_zero;
      end else begin
        pend_q <= (pend_q & ~commit) | req_rise;
        if (step && cnt_last) done_q <= 1'b1;
      end
      if (st_q == ST_RD) hold_q <= data_i;
    end
  end

  assign drv    = drv_q;
  assign done   = done_q;
  assign data_o = hold_q;

  // R2: nothing is driven onto the bus without the grant
  assert_grant_first_R2: assert property (@(posedge clk) disable iff (rst)
    (drv_q.addr_oe || drv_q.dev_ack || !drv_q.rd_n || !drv_q.wr_n) |-> bus_ack);

  // R3: the RAM strobe only comes with a driven address and lasts one cycle
  assert_wr_with_addr_R3: assert property (@(posedge clk) disable iff (rst)
    !drv_q.wr_n |-> drv_q.addr_oe);
  assert_wr_single_R3: assert property (@(posedge clk) disable iff (rst)
    !drv_q.wr_n |=> drv_q.wr_n);

  // R4: acknowledge and address are gone before the bus request drops
  assert_release_order_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(drv_q.bus_req) |-> !$past(drv_q.addr_oe) && !$past(drv_q.dev_ack));

  // R7: a buffered read is followed by the write of the held byte
  assert_read_then_write_R7: assert property (@(posedge clk) disable iff (rst)
    !drv_q.rd_n |=> !drv_q.wr_n && drv_q.data_oe && !drv_q.dev_ack);

  // R8: no new bus tenure once the count has run out
  assert_idle_when_done_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(drv_q.bus_req) |-> !done_q);

endmodule

// File: rtl/dma_channel.sv
module dma_channel
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_load,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [CNT_W-1:0]  cfg_len,
  input  logic              cfg_edge,
  input  logic              cfg_buffered,
  input  logic              dev_req,
  output logic              dev_ack,
  output logic              bus_req,
  input  logic              bus_ack,
  output logic [ADDR_W-1:0] addr_o,
  output logic              addr_oe,
  output logic              wr_n,
  output logic              rd_n,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe,
  output logic              done
);

  logic     req_level, req_rise;
  logic     load_ok, step, cnt_zero, cnt_last;
  dma_drv_t drv;

  dma_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .req_async (dev_req),
    .req_level (req_level),
    .req_rise  (req_rise)
  );

  dma_addr_cnt #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ptr (
    .clk       (clk),
    .rst       (rst),
    .load      (load_ok),
    .load_addr (cfg_base),
    .load_cnt  (cfg_len),
    .step      (step),
    .addr      (addr_o),
    .cnt_zero  (cnt_zero),
    .cnt_last  (cnt_last)
  );

  dma_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .cfg_load     (cfg_load),
    .cfg_edge     (cfg_edge),
    .cfg_buffered (cfg_buffered),
    .cfg_len_zero (cfg_len == '0),
    .req_level    (req_level),
    .req_rise     (req_rise),
    .bus_ack      (bus_ack),
    .cnt_zero     (cnt_zero),
    .cnt_last     (cnt_last),
    .data_i       (data_i),
    .load_ok      (load_ok),
    .step         (step),
    .done         (done),
    .data_o       (data_o),
    .drv          (drv)
  );

  assign bus_req = drv.bus_req;
  assign dev_ack = drv.dev_ack;
  assign addr_oe = drv.addr_oe;
  assign data_oe = drv.data_oe;
  assign wr_n    = drv.wr_n;
  assign rd_n    = drv.rd_n;

endmodule

// File: tb/tb_dma_channel.sv
module tb_dma_channel;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_load = 1'b0;
  logic [15:0] cfg_base = '0;
  logic [7:0]  cfg_len = '0;
  logic        cfg_edge = 1'b0;
  logic        cfg_buffered = 1'b0;
  logic        dev_req = 1'b0;
  logic        bus_ack = 1'b0;
  logic        dev_ack, bus_req, addr_oe, wr_n, rd_n, data_oe, done;
  logic [15:0] addr_o;
  logic [7:0]  data_i, data_o;

  int n_chk = 0, n_fail = 0;
  int wr_cnt, bad_wr, dev_idx, tenures, busy_cyc, seed;
  logic [15:0] base_cur;
  int len_cur;
  logic [7:0] mem [0:63];
  logic ack_prev = 1'b0, req_prev = 1'b0;

  always #5 clk = ~clk;

  dma_channel dut (
    .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_base(cfg_base), .cfg_len(cfg_len),
    .cfg_edge(cfg_edge), .cfg_buffered(cfg_buffered), .dev_req(dev_req), .dev_ack(dev_ack),
    .bus_req(bus_req), .bus_ack(bus_ack), .addr_o(addr_o), .addr_oe(addr_oe), .wr_n(wr_n),
    .rd_n(rd_n), .data_i(data_i), .data_o(data_o), .data_oe(data_oe), .done(done)
  );

  function automatic logic [7:0] pat(int i);
    return 8'(i * 29 + seed);
  endfunction

  assign data_i = pat(dev_idx);

  // processor, peripheral and RAM models, all acting at the falling edge
  always @(negedge clk) begin
    int idx;
    bus_ack = bus_req;
    if (!wr_n && addr_oe) begin
      wr_cnt++;
      idx = int'(16'(addr_o - base_cur));
      if (idx >= len_cur || idx > 63) bad_wr++;
      else mem[idx] = data_oe ? data_o : pat(dev_idx);
    end
    if (ack_prev && !dev_ack) dev_idx++;
    ack_prev = dev_ack;
    if (bus_req && !req_prev) tenures++;
    req_prev = bus_req;
    if (bus_req) busy_cyc++;
  end

  task automatic check(input bit ok, input string rq, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic tick;
    @(negedge clk);
    #1;
  endtask

  task automatic wait_idle;
    for (int g = 0; g < 60 && (bus_req || bus_ack); g++) tick;
    repeat (2) tick;
  endtask

  task automatic prep(input logic [15:0] base, input int len);
    base_cur = base; len_cur = len; wr_cnt = 0; bad_wr = 0; dev_idx = 0;
    tenures = 0; busy_cyc = 0; seed = len * 13 + int'(base[7:0]);
    for (int i = 0; i < 64; i++) mem[i] = 8'hxx;
  endtask

  task automatic load(input logic [15:0] base, input int len, input bit ed, input bit bf);
    cfg_base = base; cfg_len = 8'(len); cfg_edge = ed; cfg_buffered = bf; cfg_load = 1'b1;
    tick;
    cfg_load = 1'b0;
  endtask

  task automatic check_mem(input string rq);
    int bad = 0;
    for (int i = 0; i < len_cur; i++) if (mem[i] !== pat(i)) bad++;
    check(bad == 0, rq, "RAM bytes not matching pattern", bad, 0);
  endtask

  // first byte of a run, counted edge by edge from the request
  task automatic timed_first(input bit ed, input bit bf, input logic [15:0] base, input int len);
    dev_req = 1'b1;
    tick;
    check(bus_req == 0, "R2", "bus_req after 1 edge", bus_req, 0);
    tick;
    check(bus_req == 0 && addr_oe == 0, "R2", "bus_req after 2 edges", bus_req, 0);
    tick;
    check(bus_req == 1, "R2", "bus_req after 3 edges", bus_req, 1);
    check(addr_oe == 0 && dev_ack == 0 && wr_n == 1 && rd_n == 1, "R2", "drive before grant", addr_oe | dev_ack, 0);
    tick;
    if (bf) begin
      check(rd_n == 0 && dev_ack == 1 && addr_oe == 0 && wr_n == 1, "R7", "read phase rd_n", rd_n, 0);
      tick;
      check(wr_n == 0 && addr_oe == 1 && data_oe == 1 && dev_ack == 0, "R7", "write phase wr_n", wr_n, 0);
      check(data_o == pat(0), "R7", "held byte", data_o, pat(0));
      check(addr_o == base, "R7", "write address", addr_o, base);
    end else begin
      check(wr_n == 0 && addr_oe == 1 && dev_ack == 1 && data_oe == 0, "R3", "fly-by write wr_n", wr_n, 0);
      check(addr_o == base, "R3", "write address", addr_o, base);
    end
    tick;
    check(bus_req == 1 && addr_oe == 0 && dev_ack == 0 && wr_n == 1, "R4", "tail cycle addr_oe", addr_oe, 0);
    tick;
    if (ed || len == 1) begin
      check(bus_req == 0, "R4", "bus_req after tail", bus_req, 0);
    end else begin
      check(bus_req == 1, "R6", "bus held for next byte", bus_req, 1);
      if (bf) check(rd_n == 0, "R6", "next read follows tail", rd_n, 0);
      else check(wr_n == 0 && addr_o == 16'(base + 1), "R6", "next write address", addr_o, 16'(base + 1));
    end
  endtask

  task automatic run(input bit ed, input bit bf, input logic [15:0] base, input int len, input bit poke);
    prep(base, len);
    load(base, len, ed, bf);
    check(done == 0, "R9", "done after load", done, 0);
    if (ed) begin
      for (int k = 0; k < len; k++) begin
        if (k == 0) timed_first(ed, bf, base, len);
        else dev_req = 1'b1;
        repeat (14) tick;
        check(dev_idx == k + 1, "R5", "bytes after held edge", dev_idx, k + 1);
        dev_req = 1'b0;
        repeat (4) tick;
      end
    end else begin
      timed_first(ed, bf, base, len);
      if (poke) begin
        cfg_base = 16'h0000; cfg_len = 8'd1; cfg_edge = 1'b1; cfg_load = 1'b1;
        tick;
        cfg_load = 1'b0;
      end
      for (int g = 0; g < 200 && !done; g++) tick;
      dev_req = 1'b0;
    end
    wait_idle;
    check(done == 1, "R8", "done at end", done, 1);
    check(wr_cnt == len, "R8", "bytes written", wr_cnt, len);
    check(bad_wr == 0, poke ? "R9" : "R8", "writes outside window", bad_wr, 0);
    check_mem(bf ? "R7" : "R3");
    if (ed) begin
      check(tenures == len, "R5", "bus tenures", tenures, len);
      check(busy_cyc == len * (bf ? 4 : 3), "R5", "bus busy cycles", busy_cyc, len * (bf ? 4 : 3));
    end else begin
      check(tenures == 1, "R6", "bus tenures", tenures, 1);
      check(busy_cyc == 1 + len * (bf ? 3 : 2), bf ? "R7" : "R6", "bus busy cycles", busy_cyc, 1 + len * (bf ? 3 : 2));
    end
    dev_req = 1'b1;
    repeat (10) tick;
    check(tenures == (ed ? len : 1) && bus_req == 0, "R8", "request while done", tenures, ed ? len : 1);
    dev_req = 1'b0;
    repeat (4) tick;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    tick;
    check(bus_req == 0 && dev_ack == 0 && addr_oe == 0 && data_oe == 0, "R1", "drives in reset", bus_req, 0);
    check(wr_n == 1 && rd_n == 1 && done == 0, "R1", "strobes in reset", wr_n, 1);
    rst = 1'b0;
    repeat (3) tick;
    check(bus_req == 0 && wr_n == 1 && rd_n == 1 && done == 0, "R1", "idle after reset", bus_req, 0);

    // zero-length load: done at once, no tenure
    prep(16'h0200, 0);
    load(16'h0200, 0, 1'b0, 1'b0);
    check(done == 1, "R9", "done after zero load", done, 1);
    dev_req = 1'b1;
    repeat (10) tick;
    check(tenures == 0 && bus_req == 0, "R9", "tenures on zero load", tenures, 0);
    dev_req = 1'b0;
    repeat (4) tick;

    // sweep over request style, transfer style and length
    for (int e = 0; e < 2; e++)
      for (int b = 0; b < 2; b++)
        for (int l = 0; l < 3; l++)
          run(e[0], b[0], 16'(16'h1000 + e * 16'h100 + b * 16'h40 + l * 8), (l == 2) ? 5 : l + 1, 1'b0);

    // address wrap and a configuration attempt during a run
    run(1'b0, 1'b1, 16'hFFFE, 3, 1'b0);
    run(1'b0, 1'b0, 16'h0100, 4, 1'b1);

    // level request dropped mid-burst, then raised again
    prep(16'h0400, 6);
    load(16'h0400, 6, 1'b0, 1'b0);
    dev_req = 1'b1;
    for (int g = 0; g < 100 && !(!wr_n && addr_o == 16'h0401); g++) tick;
    dev_req = 1'b0;
    repeat (12) tick;
    check(wr_cnt == 3 && bus_req == 0, "R6", "bytes before release", wr_cnt, 3);
    dev_req = 1'b1;
    for (int g = 0; g < 200 && !done; g++) tick;
    dev_req = 1'b0;
    wait_idle;
    check(wr_cnt == 6, "R6", "bytes after resume", wr_cnt, 6);
    check(tenures == 2, "R6", "tenures after drop", tenures, 2);
    check_mem("R6");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule